// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital side of an 8-bit successive-approximation analog-to-digital converter in a small microcontroller. Software reaches it through three byte-wide registers: a control register, a clock/interrupt register and a read-only result register. The block decodes the start bit, selects one of four analog channels and derives the conversion tick from the system clock with a programmable divider. It runs a binary search on a DAC code against a one-bit comparator input, then stores the result, drops the busy flag and raises an interrupt request.

The comparator, DAC, analog channel mux and CPU sit outside the block. Software raises the start bit and then lowers it to launch a conversion. Keeping the bit raised holds the converter in reset. A zero pin-configuration field powers the converter down.

Top module: `sar_adc_seq`

## Requirements
- R1: A conversion starts only on a control-register write that clears the start bit (bit 6) while it was set and leaves the pin-configuration field nonzero. A write with the start bit already low does not start one.
- R2: While the start bit is set, no conversion runs and the end-of-conversion flag (control bit 7) reads 1. This holds even if a conversion was running when the bit was set.
- R3: The end-of-conversion flag is active low. It stays 1 from the start write until the conversion ends, and it reads 0 from the cycle after the last tick of the conversion.
- R4: When a conversion ends, the result register (address 2) takes the code and the request flag (address 1 bit 5) is set. The `irq` output is high only while both the flag and the enable (address 1 bit 4) are 1.
- R5: The channel field is control bits 2:0. Bit 2 always reads 0, and `ch_sel` carries bits 1:0.
- R6: The pin-configuration field is control bits 5:3. A value of 4 or more sets `analog_en` to 1111. A value n from 1 to 3 makes pins 0 to n-1 analog. A value of 0 gives `analog_en`=0000 and `adc_pd`=1, and start requests are then ignored.
- R7: The tick divider select is address 1 bits 2:0: 000=/2, 001=/8, 010=/32, 011=/128, 100=/4, 101=/16, 110=/64. A value of 111 stops the ticks. A conversion lasts 10 ticks, so it ends 10×ratio clock edges after the start write.
- R8: The first 2 ticks sample. The next 8 ticks test the bits from MSB down to LSB on `dac_code`, and each trial bit is kept when `cmp_in` is 1.
- R9: A new start trigger during a conversion aborts it and restarts from sampling. The result register keeps its old value until a conversion completes.
- R10: Writing address 1 with bit 5 at 0 clears the request flag. Writing it with bit 5 at 1 leaves the flag unchanged.
- R11: After reset, the control register reads 0x80, the other registers read 0, `irq` is 0 and `adc_pd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 clock/interrupt, 2 result |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code | output | 8 | Trial code to the DAC |
| ch_sel | output | 2 | Analog channel select |
| analog_en | output | 4 | Per-pin analog-mode enables |
| adc_pd | output | 1 | Converter power-down |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default values: 8 result bits and 2 sampling ticks. This makes the conversion window 10 ticks, and every divider ratio up to /128 can be timed exactly to the edge in a few thousand cycles. The comparator model reports whether the DAC code is at or below a chosen input level. The search should therefore return that level exactly, including the all-zeros and all-ones extremes.

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int RES_W     = 8,
  parameter int SMP_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [1:0]       ch_sel,
  output logic [3:0]       analog_en,
  output logic             adc_pd,
  output logic             irq
);
  localparam int BW = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam int SW = (SMP_TICKS > 1) ? $clog2(SMP_TICKS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SMP, S_CONV} state_t;
  state_t state;

  logic [1:0]       chan_q;
  logic [2:0]       pcfg_q, dsel_q;
  logic             start_q, eoc_n, ie_q, flag_q;
  logic [RES_W-1:0] res_q, sar_q, sar_nxt;
  logic [BW-1:0]    bidx_q;
  logic [SW-1:0]    scnt_q;
  logic [7:0]       cnt_q, ratio;

  wire wr_ctl  = wr_en && addr == 2'd0;
  wire wr_cfg  = wr_en && addr == 2'd1;
  wire trig    = wr_ctl && start_q && !wdata[6] && wdata[5:3] != 3'd0;
  wire hold    = start_q || pcfg_q == 3'd0 || (wr_ctl && (wdata[6] || wdata[5:3] == 3'd0));
  wire stopped = dsel_q == 3'd7;

  assign ratio = dsel_q[2] ? (8'd4 << {dsel_q[1:0], 1'b0}) : (8'd2 << {dsel_q[1:0], 1'b0});
  wire tick = state != S_IDLE && !stopped && cnt_q == ratio - 8'd1;

  always_comb begin
    sar_nxt = sar_q;
    if (!cmp_in) sar_nxt[bidx_q] = 1'b0;
    if (bidx_q != '0) sar_nxt[bidx_q - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; chan_q <= '0; pcfg_q <= '0; dsel_q <= '0;
      start_q <= 1'b0; eoc_n <= 1'b1; ie_q <= 1'b0; flag_q <= 1'b0;
      res_q <= '0; sar_q <= '0; bidx_q <= '0; scnt_q <= '0; cnt_q <= '0;
    end else begin
      if (wr_ctl) begin
        chan_q  <= wdata[1:0];
        pcfg_q  <= wdata[5:3];
        start_q <= wdata[6];
        if (wdata[6]) eoc_n <= 1'b1;
      end
      if (wr_cfg) begin
        dsel_q <= wdata[2:0];
        ie_q   <= wdata[4];
        if (!wdata[5]) flag_q <= 1'b0;
      end
      cnt_q <= (state == S_IDLE || tick) ? 8'd0 : cnt_q + 8'd1;
      if (tick && !hold) begin
        case (state)
          S_SMP:
            if (scnt_q == SW'(SMP_TICKS - 1)) begin
              state  <= S_CONV;
              sar_q  <= RES_W'(1) << (RES_W - 1);
              bidx_q <= BW'(RES_W - 1);
            end else scnt_q <= scnt_q + 1'b1;
          S_CONV: begin
            sar_q <= sar_nxt;
            if (bidx_q == '0) begin
              res_q  <= sar_nxt;
              eoc_n  <= 1'b0;
              flag_q <= 1'b1;
              state  <= S_IDLE;
            end else bidx_q <= bidx_q - 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
      if (hold) begin
        state <= S_IDLE;
        cnt_q <= 8'd0;
      end
      if (trig) begin
        state  <= S_SMP;
        scnt_q <= '0;
        cnt_q  <= 8'd0;
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {eoc_n, start_q, pcfg_q, 1'b0, chan_q};
      2'd1:    rdata = {2'b00, flag_q, ie_q, 1'b0, dsel_q};
      2'd2:    rdata = 8'(res_q);
      default: rdata = 8'h00;
    endcase
  end

  assign dac_code  = sar_q;
  assign ch_sel    = chan_q;
  assign adc_pd    = pcfg_q == 3'd0;
  assign analog_en = pcfg_q[2] ? 4'hF : 4'((5'd1 << pcfg_q) - 5'd1);
  assign irq       = flag_q && ie_q;

  p_hold_eoc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (eoc_n && state == S_IDLE));
  p_busy_eoc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_IDLE |-> eoc_n);
  p_done_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_n) |-> (flag_q && res_q == dac_code));
  p_pd_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pcfg_q) == 3'd0 && pcfg_q == 3'd0) |-> state == S_IDLE);
  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && stopped) |=> $stable(dac_code));
endmodule

// File: tb/tb_sar_adc_seq.sv
module tb_sar_adc_seq;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cmp_in;
  logic [1:0] addr = '0, ch_sel;
  logic [7:0] wdata = '0, rdata, dac_code, vin = '0, d;
  logic [3:0] analog_en;
  logic       adc_pd, irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign cmp_in = dac_code <= vin;

  sar_adc_seq dut (.clk, .rst_n, .wr_en, .addr, .wdata, .rdata, .cmp_in,
                   .dac_code, .ch_sel, .analog_en, .adc_pd, .irq);

  localparam logic [10:0] VEC [8] = '{
    {3'd0, 8'h00}, {3'd0, 8'hFF}, {3'd4, 8'hA5}, {3'd1, 8'h5A},
    {3'd5, 8'h01}, {3'd2, 8'h80}, {3'd6, 8'h7F}, {3'd3, 8'h3C}};

  function automatic int ratio_of(input logic [2:0] s);
    return s[2] ? (4 << (2 * s[1:0])) : (2 << (2 * s[1:0]));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic launch(input logic [1:0] ch);
    wr(0, 8'h60 | ch);
    wr(0, 8'h20 | ch);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3); rst_n = 1'b1; wait_cyc(1);
    rd(0, d); chk("R11 ctrl", d, 8'h80);
    rd(1, d); chk("R11 cfg", d, 8'h00);
    rd(2, d); chk("R11 result", d, 8'h00);
    chk("R11 irq", irq, 0);
    chk("R11 adc_pd", adc_pd, 1);

    wr(0, 8'h27);
    rd(0, d); chk("R5 chan mask", d, 8'hA3);
    chk("R5 ch_sel", ch_sel, 3);
    chk("R6 pcfg4", analog_en, 4'hF);
    wr(0, 8'h10);
    chk("R6 pcfg2", analog_en, 4'h3);
    chk("R6 pcfg2 pd", adc_pd, 0);
    wr(0, 8'h30);
    chk("R6 pcfg6", analog_en, 4'hF);

    for (int i = 0; i < 8; i++) begin
      automatic int r = ratio_of(VEC[i][10:8]);
      wr(1, {3'b000, 1'b1, 1'b0, VEC[i][10:8]});
      vin = VEC[i][7:0];
      wr(0, 8'h60 | 8'(i % 4));
      rd(0, d); chk("R2 eoc while start high", d[7], 1);
      wr(0, 8'h20 | 8'(i % 4));
      wait_cyc(10 * r - 1);
      rd(0, d); chk("R3/R7 eoc still busy", d[7], 1);
      wait_cyc(1);
      rd(0, d); chk("R3/R7 eoc cleared", d[7], 0);
      rd(2, d); chk("R8 result", d, vin);
      chk("R4 irq", irq, 1);
      chk("R5 ch_sel", ch_sel, i % 4);
    end

    wr(1, 8'h30);
    chk("R10 write 1 keeps flag", irq, 1);
    wr(1, 8'h10);
    chk("R10 clear flag irq", irq, 0);
    rd(1, d); chk("R10 flag read", d[5], 0);

    wr(0, 8'h20);
    wait_cyc(40);
    rd(0, d); chk("R1 no trigger", d[7], 0);

    wr(1, 8'h00);
    vin = 8'h33;
    launch(0);
    wait_cyc(20);
    rd(2, d); chk("R4 result ie off", d, 8'h33);
    chk("R4 irq gated", irq, 0);
    rd(1, d); chk("R4 flag set", d[5], 1);

    vin = 8'hC4;
    launch(1);
    wait_cyc(8);
    wr(0, 8'h61);
    rd(0, d); chk("R2 abort eoc", d[7], 1);
    wait_cyc(40);
    rd(0, d); chk("R2 held eoc", d[7], 1);
    rd(2, d); chk("R9 result kept", d, 8'h33);
    wr(0, 8'h21);
    wait_cyc(19);
    rd(0, d); chk("R9 busy after restart", d[7], 1);
    wait_cyc(1);
    rd(2, d); chk("R9 result new", d, 8'hC4);

    vin = 8'h19;
    launch(2);
    wait_cyc(9);
    rd(2, d); chk("R9 mid-conv result", d, 8'hC4);
    launch(2);
    wait_cyc(19);
    rd(0, d); chk("R9 restart timing busy", d[7], 1);
    wait_cyc(1);
    rd(0, d); chk("R9 restart timing done", d[7], 0);
    rd(2, d); chk("R9 restart result", d, 8'h19);

    vin = 8'h77;
    wr(0, 8'h40);
    wr(0, 8'h00);
    chk("R6 pd", adc_pd, 1);
    chk("R6 pd analog", analog_en, 0);
    wait_cyc(40);
    rd(0, d); chk("R6 start ignored eoc", d[7], 1);
    rd(2, d); chk("R6 start ignored result", d, 8'h19);

    wr(1, 8'h17);
    launch(0);
    wait_cyc(300);
    rd(0, d); chk("R7 stopped divider", d[7], 1);
    rd(2, d); chk("R7 stopped result", d, 8'h19);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule